// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address within a 1 MB space. It does this by shifting the segment left by four bits and adding the offset. A requester gives an access class with each request strobe, and the class picks a fixed segment/offset pairing. The block holds the four segment bases itself and loads them through a simple write port. The offsets (instruction pointer, stack pointer, base pointer, source index, destination index and an already computed effective address) arrive as live inputs.

The result is registered. One cycle after a request strobe is sampled, `addr_out` carries the address and `addr_valid` is high for that cycle. A two-state controller sequences this. `ST_IDLE` means no address is being presented. `ST_SHOW` means the registered address is valid. The transition `IDLE->SHOW` happens when a request is sampled. `SHOW->SHOW` happens on back-to-back requests. `SHOW->IDLE` happens when no request is sampled. `IDLE->IDLE` happens while the block stays quiet.

Top module: `seg_addr_gen`

## Requirements
- R1: The address equals (segment << 4) + offset with the carry out of bit 19 dropped, so the sum wraps modulo 1 MB (for example 0xFFFF:0xFFFF gives 0x0FFEF, and 0x456A:0x1620 gives 0x46CC0).
- R2: Class 0 (instruction fetch) pairs the code segment with `ip`.
- R3: Class 1 (push/pop) pairs the stack segment with `sp`, and class 2 (based stack access) pairs the stack segment with `bp`.
- R4: Class 3 pairs the data segment with `si`, class 4 pairs the data segment with `di`, and classes 6 and 7 pair the data segment with `ea`.
- R5: Class 5 (string destination) always pairs the extra segment with `di`.
- R6: A write with `seg_wr_en` high loads `seg_wr_data` into the segment chosen by `seg_wr_sel` (0 code, 1 stack, 2 data, 3 extra). The new value is used by requests sampled from the next cycle on. A request sampled in the same cycle as the write uses the old value.
- R7: `addr_valid` is high in exactly the cycles that follow a cycle in which `req` was sampled high. Back-to-back requests give back-to-back valid cycles, each carrying its own address.
- R8: `addr_out` keeps its value in every cycle that follows a cycle with no request.
- R9: While `rst_n` is low and after it is released, `addr_valid` and `addr_out` are zero and all four segments read as zero, until a write or a request changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write: 0 code, 1 stack, 2 data, 3 extra |
| seg_wr_data | input | 16 | New segment base |
| req | input | 1 | Address request strobe |
| req_class | input | 3 | Access class that picks the segment/offset pairing |
| ip | input | 16 | Instruction pointer offset |
| sp | input | 16 | Stack pointer offset |
| bp | input | 16 | Base pointer offset |
| si | input | 16 | Source index offset |
| di | input | 16 | Destination index offset |
| ea | input | 16 | Precomputed effective address offset |
| addr_out | output | 20 | Registered physical address |
| addr_valid | output | 1 | High for the cycle the address answers a request |

## Verification
Every offset input is driven with a different random value on each request. A class that reads the wrong offset therefore gives a wrong address. The four segments are loaded with distinct random bases, so a wrong segment pairing shows up as well. Directed cases cover the wrap at 0xFFFF:0xFFFF and a carry that ripples across the shifted nibble boundary, which separate a correct 20-bit sum from a truncated or unshifted one. A request issued in the same cycle as a segment write, back-to-back requests, and idle cycles after a request separate the write timing, the valid pulse and the output hold behaviour.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int ADDR_W    = 20;
    localparam int NSEG      = 4;
    localparam int SEL_W     = $clog2(NSEG);
    localparam int CLASS_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [CLASS_W-1:0] {
        ACC_FETCH   = 3'd0,
        ACC_PUSHPOP = 3'd1,
        ACC_BASED   = 3'd2,
        ACC_DATA_SI = 3'd3,
        ACC_DATA_DI = 3'd4,
        ACC_STR_DST = 3'd5,
        ACC_DATA_EA = 3'd6,
        ACC_DATA_EB = 3'd7
    } acc_class_e;

    typedef enum logic [2:0] {
        OFS_IP,
        OFS_SP,
        OFS_BP,
        OFS_SI,
        OFS_DI,
        OFS_EA
    } ofs_src_e;

    typedef struct packed {
        seg_id_e  seg;
        ofs_src_e ofs;
    } pairing_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } gen_state_e;

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_addr_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int W  = SEG_W,
    parameter int SW = SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SW-1:0]       wr_sel,
    input  logic [W-1:0]        wr_data,
    output logic [N-1:0][W-1:0] seg_q
);

    for (genvar g = 0; g < N; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                seg_q[g] <= '0;
            end else if (wr_en && (wr_sel == SW'(g))) begin
                seg_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/seg_pair_sel.sv
module seg_pair_sel
    import seg_addr_pkg::*;
#(
    parameter int N  = NSEG,
    parameter int SW = SEG_W,
    parameter int OW = OFF_W
) (
    input  acc_class_e          cls,
    input  logic [N-1:0][SW-1:0] segs,
    input  logic [OW-1:0]       ip,
    input  logic [OW-1:0]       sp,
    input  logic [OW-1:0]       bp,
    input  logic [OW-1:0]       si,
    input  logic [OW-1:0]       di,
    input  logic [OW-1:0]       ea,
    output logic [SW-1:0]       seg_val,
    output logic [OW-1:0]       ofs_val
);

    pairing_t pair;

    // Fixed class-to-pairing table
    always_comb begin
        unique case (cls)
            ACC_FETCH:   pair = '{seg: SEG_CODE,  ofs: OFS_IP};
            ACC_PUSHPOP: pair = '{seg: SEG_STACK, ofs: OFS_SP};
            ACC_BASED:   pair = '{seg: SEG_STACK, ofs: OFS_BP};
            ACC_DATA_SI: pair = '{seg: SEG_DATA,  ofs: OFS_SI};
            ACC_DATA_DI: pair = '{seg: SEG_DATA,  ofs: OFS_DI};
            ACC_STR_DST: pair = '{seg: SEG_EXTRA, ofs: OFS_DI};
            ACC_DATA_EA: pair = '{seg: SEG_DATA,  ofs: OFS_EA};
            ACC_DATA_EB: pair = '{seg: SEG_DATA,  ofs: OFS_EA};
            default:     pair = '{seg: SEG_DATA,  ofs: OFS_EA};
        endcase
    end

    assign seg_val = segs[pair.seg];

    always_comb begin
        unique case (pair.ofs)
            OFS_IP:  ofs_val = ip;
            OFS_SP:  ofs_val = sp;
            OFS_BP:  ofs_val = bp;
            OFS_SI:  ofs_val = si;
            OFS_DI:  ofs_val = di;
            OFS_EA:  ofs_val = ea;
            default: ofs_val = ea;
        endcase
    end

endmodule

// File: rtl/seg_shift_add.sv
module seg_shift_add
    import seg_addr_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFF_W,
    parameter int SH = SEG_SHIFT,
    parameter int AW = ADDR_W
) (
    input  logic [SW-1:0] seg,
    input  logic [OW-1:0] ofs,
    output logic [AW-1:0] phys
);

    localparam int BASE_W = SW + SH;
    localparam int SUM_W  = ((BASE_W > OW) ? BASE_W : OW) + 1;

    logic [BASE_W-1:0] base;
    logic [SUM_W-1:0]  sum;

    assign base = {seg, {SH{1'b0}}};
    assign sum  = SUM_W'(base) + SUM_W'(ofs);
    // Upper carry discarded: the space wraps
    assign phys = sum[AW-1:0];

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req,
    input  logic [CLASS_W-1:0] req_class,
    input  logic [OFF_W-1:0]  ip,
    input  logic [OFF_W-1:0]  sp,
    input  logic [OFF_W-1:0]  bp,
    input  logic [OFF_W-1:0]  si,
    input  logic [OFF_W-1:0]  di,
    input  logic [OFF_W-1:0]  ea,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid
);

    logic [NSEG-1:0][SEG_W-1:0] segs;
    logic [SEG_W-1:0]           seg_val;
    logic [OFF_W-1:0]           ofs_val;
    logic [ADDR_W-1:0]          phys;
    gen_state_e                 state_q, state_d;

    seg_bank #(.N(NSEG), .W(SEG_W), .SW(SEL_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (segs)
    );

    seg_pair_sel #(.N(NSEG), .SW(SEG_W), .OW(OFF_W)) u_sel (
        .cls     (acc_class_e'(req_class)),
        .segs    (segs),
        .ip      (ip),
        .sp      (sp),
        .bp      (bp),
        .si      (si),
        .di      (di),
        .ea      (ea),
        .seg_val (seg_val),
        .ofs_val (ofs_val)
    );

    seg_shift_add #(.SW(SEG_W), .OW(OFF_W), .SH(SEG_SHIFT), .AW(ADDR_W)) u_add (
        .seg  (seg_val),
        .ofs  (ofs_val),
        .phys (phys)
    );

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = req ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out <= '0;
        end else if (req) begin
            addr_out <= phys;
        end
    end

    assign addr_valid = (state_q == ST_SHOW);

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
    import seg_addr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              seg_wr_en,
    input logic [SEL_W-1:0]  seg_wr_sel,
    input logic [SEG_W-1:0]  seg_wr_data,
    input logic              req,
    input logic [CLASS_W-1:0] req_class,
    input logic [OFF_W-1:0]  ip,
    input logic [OFF_W-1:0]  di,
    input logic [ADDR_W-1:0] addr_out,
    input logic              addr_valid
);

    logic [SEG_W-1:0]  sh_code, sh_extra;
    logic              live;
    logic              was_rst;
    logic [ADDR_W-1:0] exp_fetch, exp_str;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_code  <= '0;
            sh_extra <= '0;
            live     <= 1'b0;
        end else begin
            live <= 1'b1;
            if (seg_wr_en && seg_wr_sel == SEL_W'(0)) sh_code  <= seg_wr_data;
            if (seg_wr_en && seg_wr_sel == SEL_W'(3)) sh_extra <= seg_wr_data;
        end
    end

    always_ff @(posedge clk) was_rst <= !rst_n;

    assign exp_fetch = ADDR_W'({sh_code, 4'b0000})  + ADDR_W'(ip);
    assign exp_str   = ADDR_W'({sh_extra, 4'b0000}) + ADDR_W'(di);

    assert_fetch_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_class == 3'd0) |=> (addr_out == $past(exp_fetch)));

    assert_string_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_class == 3'd5) |=> (addr_out == $past(exp_str)));

    assert_valid_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (addr_valid == $past(req)));

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(req)) |-> $stable(addr_out));

    // R9: first cycle out of reset shows nothing
    always @(posedge clk) begin
        if (rst_n && was_rst) begin
            assert_reset_clear_R9: assert (!addr_valid && addr_out == '0);
        end
    end

endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_wr_en   (seg_wr_en),
    .seg_wr_sel  (seg_wr_sel),
    .seg_wr_data (seg_wr_data),
    .req         (req),
    .req_class   (req_class),
    .ip          (ip),
    .di          (di),
    .addr_out    (addr_out),
    .addr_valid  (addr_valid)
);

// File: tb/seg_addr_gen_test.sv
module seg_addr_gen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel;
    logic [15:0] seg_wr_data;
    logic        req;
    logic [2:0]  req_class;
    logic [15:0] ip, sp, bp, si, di, ea;
    logic [19:0] addr_out;
    logic        addr_valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    logic [15:0] mseg [4];

    always #4 clk = ~clk;

    seg_addr_gen uut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req(req), .req_class(req_class),
        .ip(ip), .sp(sp), .bp(bp), .si(si), .di(di), .ea(ea),
        .addr_out(addr_out), .addr_valid(addr_valid)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] t;
        t = {1'b0, s, 4'h0} + {5'h0, o};
        return t[19:0];
    endfunction

    function automatic logic [19:0] expect_addr(input logic [2:0] c);
        case (c)
            3'd0: return phys(mseg[0], ip);
            3'd1: return phys(mseg[1], sp);
            3'd2: return phys(mseg[1], bp);
            3'd3: return phys(mseg[2], si);
            3'd4: return phys(mseg[2], di);
            3'd5: return phys(mseg[3], di);
            default: return phys(mseg[2], ea);
        endcase
    endfunction

    task automatic chk(input string r, input logic [19:0] act, input logic [19:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic rand_offsets();
        ip = 16'($urandom); sp = 16'($urandom); bp = 16'($urandom);
        si = 16'($urandom); di = 16'($urandom); ea = 16'($urandom);
    endtask

    task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = v;
        @(negedge clk);
        seg_wr_en = 1'b0;
        mseg[s] = v;
    endtask

    // Request at a negedge, check at the next negedge, then go idle
    task automatic one_req(input logic [2:0] c, input string r);
        logic [19:0] e;
        @(negedge clk);
        req = 1'b1; req_class = c;
        e = expect_addr(c);
        @(negedge clk);
        req = 1'b0;
        chk(r, addr_out, e);
        chk("R7 valid", {19'b0, addr_valid}, 20'd1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0;
        req = 0; req_class = 0;
        ip = 0; sp = 0; bp = 0; si = 0; di = 0; ea = 0;
        for (int i = 0; i < 4; i++) mseg[i] = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", {19'b0, addr_valid}, 20'd0);
        chk("R9 reset addr", addr_out, 20'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 post-reset valid", {19'b0, addr_valid}, 20'd0);
        rand_offsets();
        one_req(3'd5, "R9 segments zero after reset");

        // R1 example pair
        wr_seg(2'd0, 16'h456A);
        ip = 16'h1620;
        one_req(3'd0, "R1 R2 example sum");
        // R1 wrap
        wr_seg(2'd2, 16'hFFFF);
        ea = 16'hFFFF;
        one_req(3'd6, "R1 wrap");
        // R1 carry across the nibble boundary
        wr_seg(2'd1, 16'h0FFF);
        sp = 16'h0010;
        one_req(3'd1, "R1 R3 carry ripple");

        // R8 hold while idle
        begin
            logic [19:0] held;
            held = addr_out;
            rand_offsets();
            @(negedge clk);
            chk("R8 hold", addr_out, held);
            chk("R7 idle valid", {19'b0, addr_valid}, 20'd0);
        end

        // R6 same-cycle write and request uses the old value
        begin
            logic [19:0] e;
            @(negedge clk);
            rand_offsets();
            seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 16'hA5C3;
            req = 1'b1; req_class = 3'd5;
            e = expect_addr(3'd5);
            @(negedge clk);
            seg_wr_en = 1'b0;
            req = 1'b0;
            chk("R6 old value same cycle", addr_out, e);
            mseg[3] = 16'hA5C3;
            one_req(3'd5, "R5 R6 new value next");
        end

        // R7 back-to-back requests
        begin
            logic [19:0] e1, e2;
            @(negedge clk);
            rand_offsets();
            req = 1'b1; req_class = 3'd2;
            e1 = expect_addr(3'd2);
            @(negedge clk);
            chk("R3 R7 b2b first", addr_out, e1);
            chk("R7 b2b valid1", {19'b0, addr_valid}, 20'd1);
            rand_offsets();
            req_class = 3'd4;
            e2 = expect_addr(3'd4);
            @(negedge clk);
            req = 1'b0;
            chk("R4 R7 b2b second", addr_out, e2);
            chk("R7 b2b valid2", {19'b0, addr_valid}, 20'd1);
            @(negedge clk);
            chk("R7 single pulse end", {19'b0, addr_valid}, 20'd0);
        end

        // Random segments and classes
        for (int s = 0; s < 4; s++) wr_seg(2'(s), 16'($urandom));
        for (int i = 0; i < 300; i++) begin
            if (($urandom % 8) == 0) wr_seg(2'($urandom), 16'($urandom));
            rand_offsets();
            case (i % 8)
                0: one_req(3'd0, "R2 random fetch");
                1: one_req(3'd1, "R3 random push/pop");
                2: one_req(3'd2, "R3 random based");
                3: one_req(3'd3, "R4 random data si");
                4: one_req(3'd4, "R4 random data di");
                5: one_req(3'd5, "R5 random string dst");
                6: one_req(3'd6, "R4 random data ea");
                default: one_req(3'd7, "R4 random data ea alt");
            endcase
        end

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule